// File: doc/BRIEF.md
# DRAM Write Leveling Sequencer

This block runs the controller's side of write leveling for a single rank of a DDR-style memory. When `start` is pulsed it first checks the termination setting, then programs the rank's mode register 1 into leveling mode. Before that it writes the same register on every other rank with the output buffer turned off, so that only the rank under test drives its DQ pins. After the mode-register delay it raises on-die termination and drives the strobe to its low preamble level. It then fires single strobe pulses, each followed by a wait long enough for the memory's feedback to settle on DQ.

Each sampled feedback bit moves a strobe delay tap by one step. The direction is set by the first sample: a 0 means step up, a 1 means step down. The search ends at the tap where the feedback changes from 0 to 1. The block then drops termination and the strobe, writes mode register 1 to leave leveling on all ranks, and pulses `done`. It raises `err` if the tap hits either end of its range before the edge is found. It also raises `err`, without issuing any command, if the rank's output is enabled and the termination code is not one that leveling allows. Every wait is a parameter counted in controller clock cycles.

The finite-state machine has these states:
- IDLE
- MRS_OTH: disable the outputs of the other ranks
- MRD_WAIT
- MRS_TGT: enter leveling on the target rank
- MOD_WAIT
- ODT_WAIT
- PREAMBLE
- STB_HI
- STB_LO
- STEP_GAP
- EXIT_MRS
- EXIT_WAIT
- DONE

Its transitions are:
- IDLE to MRS_OTH, or to DONE on a bad termination code.
- MRS_OTH to MRD_WAIT, then to MRS_TGT, then to MOD_WAIT, then to ODT_WAIT, then to PREAMBLE, then to STB_HI, then to STB_LO.
- STB_LO to STEP_GAP, which returns to STB_HI.
- STB_LO to EXIT_MRS on lock or saturation.
- EXIT_MRS to EXIT_WAIT, then to DONE, then back to IDLE.

Top module: `wrlvl_ctrl`

## Requirements
- R1: After reset `cmd_mrs`, `odt`, `dqs_oe`, `dqs_pulse`, `done` and `err` are 0 and `tap` equals TAP_INIT.
- R2: In the cycle after `start` is sampled, one MRS goes to every rank except `tgt_rank`. That MRS carries MR1 bit 7 = 1 and bit 12 = 1, with the termination code placed on MR1 bits 9, 6 and 2 (code bits 2, 1, 0). T_MRD cycles later an MRS goes to the target rank only, with bit 7 = 1 and bit 12 = `tgt_qoff`. `cmd_cs` bit n selects rank n.
- R3: While `odt` is high no MRS is issued. Only NOP cycles lie between the entry MRS and the exit MRS.
- R4: `odt` rises exactly T_MOD cycles after the target-rank MRS cycle.
- R5: `dqs_oe` (strobe driven low) rises exactly T_WLDQSEN cycles after `odt` rises, and is high only while `odt` is high.
- R6: The first strobe rising edge comes T_PRE = max(T_DQSL, T_WLMRD − T_MOD − T_WLDQSEN) cycles after `dqs_oe` rises. This satisfies both the low-preamble time and the delay since the entry MRS.
- R7: Each strobe pulse is high for T_DQSH cycles and then low for T_LO = max(T_DQSL, T_WLO + T_WLOE − T_DQSH) cycles. Feedback is sampled at the edge that ends the low time, which is at least T_WLO + T_WLOE cycles after the rise. Successive rises are T_DQSH + T_LO + T_GAP cycles apart.
- R8: The feedback value is the OR of all `dq_fb` bits. If the first sample is 0 the tap steps up by one per pulse until a sample of 1, and locks at that tap. If the first sample is 1 the tap steps down by one per pulse until a sample of 0, and locks at that tap plus one. The tap changes only after a sample and by at most one.
- R9: If the tap reaches its top value (stepping up) or 0 (stepping down) and the sample there still does not show the edge, the search stops with `err` = 1 and the tap left at that end.
- R10: After a lock or a saturation, `odt` and `dqs_oe` fall together with one MRS to all ranks carrying MR1 bit 7 = 0 and bit 12 = 0. `done` is high for one cycle, T_MOD cycles after that exit MRS.
- R11: If `tgt_qoff` = 0 and the termination code is not 1, 2 or 3, no command is issued, `err` = 1, the tap returns to TAP_INIT, and `done` pulses in the cycle after `start` is sampled. With `tgt_qoff` = 1 every code is accepted.
- R12: `err` and `tap` hold their final values after `done` until the next `start`. A start that is accepted clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin leveling (sampled in IDLE) |
| tgt_rank | input | RANK_W | Index of the rank to level |
| tgt_qoff | input | 1 | Output-off setting written to the target rank |
| rtt_code | input | 3 | Nominal termination code for MR1 |
| cmd_mrs | output | 1 | 1 = mode register write, 0 = NOP |
| cmd_cs | output | NRANK | Rank selects for the command |
| mr1_val | output | 16 | MR1 value carried with an MRS |
| odt | output | 1 | On-die termination enable |
| dqs_oe | output | 1 | Strobe driven (low level unless pulsing) |
| dqs_pulse | output | 1 | Strobe driven high |
| dq_fb | input | DQ_W | Leveling feedback from DQ pins |
| tap | output | TAP_W | Strobe delay tap setting |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Saturation or termination-code error |

## Verification
Every result has a fixed due cycle measured from the edge that samples `start`:
- entry MRS on the other ranks: cycle 0
- entry MRS on the target rank: cycle T_MRD
- `odt`: T_MOD cycles later
- strobe enable: T_WLDQSEN cycles after that
- first rise: T_PRE cycles after that
- exit MRS: P·(T_DQSH+T_LO) + (P−1)·T_GAP cycles after the first rise, where P is the number of pulses
- `done`: T_MOD cycles after the exit MRS

The bench works out P, the final tap and the error flag arithmetically from the feedback threshold it models. It sweeps that threshold across and beyond the tap range.

The bench samples on falling edges and logs the cycle index of every event. Each logged index is compared with its computed due cycle.

The bench's DQ model returns the inverted answer until T_WLO + T_WLOE cycles after each rise. A sample taken early therefore shows up as a wrong final tap.

// File: rtl/wrlvl_pkg.sv
package wrlvl_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_MRS_OTH,
        S_MRD_WAIT,
        S_MRS_TGT,
        S_MOD_WAIT,
        S_ODT_WAIT,
        S_PREAMBLE,
        S_STB_HI,
        S_STB_LO,
        S_STEP_GAP,
        S_EXIT_MRS,
        S_EXIT_WAIT,
        S_DONE
    } wl_state_e;

    localparam int MR1_W    = 16;
    localparam int LVL_BIT  = 7;
    localparam int QOFF_BIT = 12;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // termination codes usable while the leveled rank drives DQ
    function automatic logic rtt_allowed(input logic [2:0] code);
        return (code == 3'd1) || (code == 3'd2) || (code == 3'd3);
    endfunction

    function automatic logic [MR1_W-1:0] mr1_word(input logic lvl, input logic qoff,
                                                  input logic [2:0] rtt);
        logic [MR1_W-1:0] w;
        w           = '0;
        w[LVL_BIT]  = lvl;
        w[QOFF_BIT] = qoff;
        w[9]        = rtt[2];
        w[6]        = rtt[1];
        w[2]        = rtt[0];
        return w;
    endfunction

endpackage

// File: rtl/wrlvl_timer.sv
module wrlvl_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/wrlvl_tap.sv
module wrlvl_tap #(
    parameter int TAP_W    = 4,
    parameter int TAP_INIT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             smp,
    input  logic             fb,
    output logic [TAP_W-1:0] tap,
    output logic             lock,
    output logic             at_end
);

    localparam logic [TAP_W-1:0] TAP_MAX  = {TAP_W{1'b1}};
    localparam logic [TAP_W-1:0] TAP_RST  = TAP_W'(TAP_INIT);

    logic [TAP_W-1:0] tap_q;
    logic             first_q;
    logic             up_q;
    logic             eff_up;

    always_comb begin
        eff_up = first_q ? ~fb : up_q;
        lock   = ~first_q && (fb == up_q);
        at_end = ~lock && (eff_up ? (tap_q == TAP_MAX) : (tap_q == '0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            tap_q   <= TAP_RST;
            first_q <= 1'b1;
            up_q    <= 1'b1;
        end else if (smp) begin
            first_q <= 1'b0;
            up_q    <= eff_up;
            if (lock) begin
                if (!up_q) tap_q <= tap_q + 1'b1;
            end else if (!at_end) begin
                tap_q <= eff_up ? tap_q + 1'b1 : tap_q - 1'b1;
            end
        end
    end

    assign tap = tap_q;

    // R8
    tap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(smp) && !$past(clr)) |-> $stable(tap_q));

    // R8
    tap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp |=> (tap_q == $past(tap_q) || tap_q == $past(tap_q) + 1'b1
                 || tap_q == $past(tap_q) - 1'b1));

endmodule

// File: rtl/wrlvl_ctrl.sv
module wrlvl_ctrl
    import wrlvl_pkg::*;
#(
    parameter int NRANK     = 2,
    parameter int DQ_W      = 8,
    parameter int TAP_W     = 4,
    parameter int TAP_INIT  = 8,
    parameter int T_MRD     = 4,
    parameter int T_MOD     = 12,
    parameter int T_WLDQSEN = 25,
    parameter int T_WLMRD   = 40,
    parameter int T_DQSL    = 3,
    parameter int T_DQSH    = 3,
    parameter int T_WLO     = 7,
    parameter int T_WLOE    = 2,
    parameter int T_GAP     = 4,
    localparam int RANK_W   = (NRANK > 1) ? $clog2(NRANK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RANK_W-1:0] tgt_rank,
    input  logic              tgt_qoff,
    input  logic [2:0]        rtt_code,
    output logic              cmd_mrs,
    output logic [NRANK-1:0]  cmd_cs,
    output logic [MR1_W-1:0]  mr1_val,
    output logic              odt,
    output logic              dqs_oe,
    output logic              dqs_pulse,
    input  logic [DQ_W-1:0]   dq_fb,
    output logic [TAP_W-1:0]  tap,
    output logic              done,
    output logic              err
);

    localparam int T_PRE  = max2(max2(T_DQSL, T_WLMRD - T_MOD - T_WLDQSEN), 1);
    localparam int T_LO   = max2(max2(T_DQSL, T_WLO + T_WLOE - T_DQSH), 1);
    localparam int T_LONG = max2(max2(max2(T_MRD, T_MOD), max2(T_WLDQSEN, T_PRE)),
                                 max2(max2(T_DQSH, T_LO), T_GAP));
    localparam int CNT_W  = $clog2(T_LONG + 1);

    wl_state_e         state, state_n;
    logic              tmr_zero, tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic [RANK_W-1:0] tgt_q;
    logic              qoff_q;
    logic [2:0]        rtt_q;
    logic              err_q;
    logic              accept, bad_cfg, smp, lock, at_end, fb_bit;
    logic [NRANK-1:0]  tgt_oh;

    assign accept  = (state == S_IDLE) && start;
    assign bad_cfg = ~tgt_qoff && ~rtt_allowed(rtt_code);
    assign smp     = (state == S_STB_LO) && tmr_zero;
    assign fb_bit  = |dq_fb;
    assign tgt_oh  = NRANK'(1) << tgt_q;

    wrlvl_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    wrlvl_tap #(.TAP_W(TAP_W), .TAP_INIT(TAP_INIT)) i_tap (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (accept),
        .smp    (smp),
        .fb     (fb_bit),
        .tap    (tap),
        .lock   (lock),
        .at_end (at_end)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // captured configuration and sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q  <= '0;
            qoff_q <= 1'b0;
            rtt_q  <= '0;
            err_q  <= 1'b0;
        end else if (accept) begin
            tgt_q  <= tgt_rank;
            qoff_q <= tgt_qoff;
            rtt_q  <= rtt_code;
            err_q  <= bad_cfg;
        end else if (smp && at_end) begin
            err_q  <= 1'b1;
        end
    end

    // next state and wait length
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:      if (start) state_n = bad_cfg ? S_DONE
                                            : ((NRANK > 1) ? S_MRS_OTH : S_MRS_TGT);
            S_MRS_OTH:   state_n = S_MRD_WAIT;
            S_MRD_WAIT:  if (tmr_zero) state_n = S_MRS_TGT;
            S_MRS_TGT:   state_n = S_MOD_WAIT;
            S_MOD_WAIT:  if (tmr_zero) state_n = S_ODT_WAIT;
            S_ODT_WAIT:  if (tmr_zero) state_n = S_PREAMBLE;
            S_PREAMBLE:  if (tmr_zero) state_n = S_STB_HI;
            S_STB_HI:    if (tmr_zero) state_n = S_STB_LO;
            S_STB_LO:    if (tmr_zero) state_n = (lock || at_end) ? S_EXIT_MRS : S_STEP_GAP;
            S_STEP_GAP:  if (tmr_zero) state_n = S_STB_HI;
            S_EXIT_MRS:  state_n = S_EXIT_WAIT;
            S_EXIT_WAIT: if (tmr_zero) state_n = S_DONE;
            S_DONE:      state_n = S_IDLE;
            default:     state_n = S_IDLE;
        endcase

        tmr_load = (state_n != state);
        unique case (state_n)
            S_MRD_WAIT:  tmr_val = CNT_W'(T_MRD - 2);
            S_MOD_WAIT:  tmr_val = CNT_W'(T_MOD - 2);
            S_EXIT_WAIT: tmr_val = CNT_W'(T_MOD - 2);
            S_ODT_WAIT:  tmr_val = CNT_W'(T_WLDQSEN - 1);
            S_PREAMBLE:  tmr_val = CNT_W'(T_PRE - 1);
            S_STB_HI:    tmr_val = CNT_W'(T_DQSH - 1);
            S_STB_LO:    tmr_val = CNT_W'(T_LO - 1);
            S_STEP_GAP:  tmr_val = CNT_W'(T_GAP - 1);
            default:     tmr_val = '0;
        endcase
    end

    // outputs
    always_comb begin
        cmd_mrs   = 1'b0;
        cmd_cs    = '0;
        mr1_val   = '0;
        odt       = 1'b0;
        dqs_oe    = 1'b0;
        dqs_pulse = 1'b0;
        done      = 1'b0;
        unique case (state)
            S_MRS_OTH: begin
                cmd_mrs = 1'b1;
                cmd_cs  = ~tgt_oh;
                mr1_val = mr1_word(1'b1, 1'b1, rtt_q);
            end
            S_MRS_TGT: begin
                cmd_mrs = 1'b1;
                cmd_cs  = tgt_oh;
                mr1_val = mr1_word(1'b1, qoff_q, rtt_q);
            end
            S_ODT_WAIT: odt = 1'b1;
            S_PREAMBLE, S_STB_LO, S_STEP_GAP: begin
                odt    = 1'b1;
                dqs_oe = 1'b1;
            end
            S_STB_HI: begin
                odt       = 1'b1;
                dqs_oe    = 1'b1;
                dqs_pulse = 1'b1;
            end
            S_EXIT_MRS: begin
                cmd_mrs = 1'b1;
                cmd_cs  = '1;
                mr1_val = mr1_word(1'b0, 1'b0, rtt_q);
            end
            S_DONE:  done = 1'b1;
            default: ;
        endcase
    end

    assign err = err_q;

    // R3
    lvl_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        odt |-> !cmd_mrs);

    // R5
    strobe_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dqs_oe |-> odt);

    // R6
    preamble_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dqs_pulse) |-> $past(dqs_oe));

    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!odt && !dqs_oe && !cmd_mrs));

endmodule

// File: tb/test_wrlvl_ctrl.sv
module test_wrlvl_ctrl;

    localparam int NRANK = 2, DQ_W = 8, TAP_W = 4, TAP_INIT = 8;
    localparam int T_MRD = 4, T_MOD = 12, T_WLDQSEN = 25, T_WLMRD = 45;
    localparam int T_DQSL = 3, T_DQSH = 3, T_WLO = 7, T_WLOE = 2, T_GAP = 4;
    localparam int TMAX  = (1 << TAP_W) - 1;
    localparam int LAT   = T_WLO + T_WLOE;
    localparam int E_PRE = (T_WLMRD - T_MOD - T_WLDQSEN > T_DQSL)
                           ? T_WLMRD - T_MOD - T_WLDQSEN : T_DQSL;
    localparam int E_LO  = (LAT - T_DQSH > T_DQSL) ? LAT - T_DQSH : T_DQSL;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [0:0] tgt_rank = '0;
    logic tgt_qoff = 1'b0;
    logic [2:0] rtt_code = 3'd1;
    logic cmd_mrs, odt, dqs_oe, dqs_pulse, done, err;
    logic [NRANK-1:0] cmd_cs;
    logic [15:0] mr1_val;
    logic [DQ_W-1:0] dq_fb = '0;
    logic [TAP_W-1:0] tap;

    wrlvl_ctrl #(.NRANK(NRANK), .DQ_W(DQ_W), .TAP_W(TAP_W), .TAP_INIT(TAP_INIT),
                 .T_MRD(T_MRD), .T_MOD(T_MOD), .T_WLDQSEN(T_WLDQSEN), .T_WLMRD(T_WLMRD),
                 .T_DQSL(T_DQSL), .T_DQSH(T_DQSH), .T_WLO(T_WLO), .T_WLOE(T_WLOE),
                 .T_GAP(T_GAP)) i_wrlvl_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .tgt_rank(tgt_rank),
        .tgt_qoff(tgt_qoff), .rtt_code(rtt_code), .cmd_mrs(cmd_mrs), .cmd_cs(cmd_cs),
        .mr1_val(mr1_val), .odt(odt), .dqs_oe(dqs_oe), .dqs_pulse(dqs_pulse),
        .dq_fb(dq_fb), .tap(tap), .done(done), .err(err));

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_err = 0;
    int thr = 0;
    bit prime = 1'b0;
    bit mon_on = 1'b0;
    int base, mrs_n, odt_rise, oe_rise, rise1, pulses, hi_len, last_rise, done_cyc;
    int bad_width, bad_period, mrs_in_lvl, age;
    int mrs_cyc[3];
    int mrs_cs[3];
    int mrs_val[3];
    bit prev_odt = 0, prev_oe = 0, prev_p = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int word(input int lvl, input int qoff, input int rtt);
        return (lvl << 7) | (qoff << 12) | (((rtt >> 2) & 1) << 9)
             | (((rtt >> 1) & 1) << 6) | ((rtt & 1) << 2);
    endfunction

    // monitor and DQ feedback model, both on falling edges
    always @(negedge clk) begin
        int rel;
        bit truth, bitv;
        rel = cyc - base;
        if (mon_on) begin
            if (cmd_mrs) begin
                if (odt) mrs_in_lvl++;
                if (mrs_n < 3) begin
                    mrs_cyc[mrs_n] = rel;
                    mrs_cs[mrs_n]  = int'(cmd_cs);
                    mrs_val[mrs_n] = int'(mr1_val);
                end
                mrs_n++;
            end
            if (odt && !prev_odt && odt_rise < 0) odt_rise = rel;
            if (dqs_oe && !prev_oe && oe_rise < 0) oe_rise = rel;
            if (dqs_pulse && !prev_p) begin
                if (rise1 < 0) rise1 = rel;
                else if (rel - last_rise != T_DQSH + E_LO + T_GAP) bad_period++;
                last_rise = rel;
                pulses++;
                hi_len = 0;
            end
            if (dqs_pulse) hi_len++;
            if (!dqs_pulse && prev_p && hi_len != T_DQSH) bad_width++;
            if (done && done_cyc < 0) done_cyc = rel;
        end
        if (dqs_pulse && !prev_p) age = 1;
        else if (age < 100000) age++;
        truth = (int'(tap) >= thr);
        bitv  = (age >= LAT) ? truth : ~truth;
        dq_fb <= prime ? {{(DQ_W-1){1'b0}}, bitv} : {DQ_W{bitv}};
        prev_odt = odt;
        prev_oe  = dqs_oe;
        prev_p   = dqs_pulse;
    end

    task automatic run_case(input int thr_i, input int rank, input bit qoff,
                            input int rtt, input bit prime_i);
        bit bad;
        int e_tap, e_err, np, t_odt, t_oe, t_r1, t_exit, waited;
        @(negedge clk);
        thr = thr_i; prime = prime_i;
        tgt_rank = rank[0:0]; tgt_qoff = qoff; rtt_code = rtt[2:0];
        base = cyc + 1; mrs_n = 0; odt_rise = -1; oe_rise = -1; rise1 = -1;
        pulses = 0; hi_len = 0; last_rise = 0; done_cyc = -1;
        bad_width = 0; bad_period = 0; mrs_in_lvl = 0;
        mon_on = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while (done_cyc < 0 && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        @(negedge clk);
        mon_on = 1'b0;
        bad = !qoff && !(rtt >= 1 && rtt <= 3);
        if (bad) begin
            // R11: rejected code, no command, immediate done
            chk("R11 done cycle", done_cyc, 0);
            chk("R11 mrs count", mrs_n, 0);
            chk("R11 err", int'(err), 1);
            chk("R11 tap", int'(tap), TAP_INIT);
            e_tap = TAP_INIT; e_err = 1;
        end else begin
            e_tap = (thr_i > TMAX) ? TMAX : thr_i;
            e_err = (thr_i == 0 || thr_i > TMAX) ? 1 : 0;
            if (thr_i > TAP_INIT) np = (thr_i > TMAX) ? TMAX - TAP_INIT + 1 : thr_i - TAP_INIT + 1;
            else                  np = (thr_i == 0) ? TAP_INIT + 1 : TAP_INIT - thr_i + 2;
            t_odt  = T_MRD + T_MOD;
            t_oe   = t_odt + T_WLDQSEN;
            t_r1   = t_oe + E_PRE;
            t_exit = t_r1 + np * (T_DQSH + E_LO) + (np - 1) * T_GAP;
            chk("R2 mrs count", mrs_n, 3);
            chk("R2 other mrs cycle", mrs_cyc[0], 0);
            chk("R2 other mrs cs", mrs_cs[0], 3 ^ (1 << rank));
            chk("R2 other mrs value", mrs_val[0], word(1, 1, rtt));
            chk("R2 target mrs cycle", mrs_cyc[1], T_MRD);
            chk("R2 target mrs cs", mrs_cs[1], 1 << rank);
            chk("R2 target mrs value", mrs_val[1], word(1, int'(qoff), rtt));
            chk("R3 mrs during leveling", mrs_in_lvl, 0);
            chk("R4 odt rise", odt_rise, t_odt);
            chk("R5 strobe enable rise", oe_rise, t_oe);
            chk("R6 first strobe rise", rise1, t_r1);
            chk("R7 pulse width errors", bad_width, 0);
            chk("R7 pulse period errors", bad_period, 0);
            chk("R8 pulse count", pulses, np);
            chk("R8 final tap", int'(tap), e_tap);
            chk("R9 err flag", int'(err), e_err);
            chk("R10 exit mrs cycle", mrs_cyc[2], t_exit);
            chk("R10 exit mrs cs", mrs_cs[2], 3);
            chk("R10 exit mrs value", mrs_val[2], word(0, 0, rtt));
            chk("R10 done cycle", done_cyc, t_exit + T_MOD);
        end
        repeat (5) @(negedge clk);
        chk("R12 err held", int'(err), e_err);
        chk("R12 tap held", int'(tap), e_tap);
        chk("R10 done single cycle", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 cmd_mrs", int'(cmd_mrs), 0);
        chk("R1 odt", int'(odt), 0);
        chk("R1 dqs_oe", int'(dqs_oe), 0);
        chk("R1 dqs_pulse", int'(dqs_pulse), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 err", int'(err), 0);
        chk("R1 tap", int'(tap), TAP_INIT);
        for (int t = 0; t <= TMAX + 2; t++)
            run_case(t, t % 2, 1'b0, 1 + (t % 3), (t % 3) == 0);
        for (int c = 0; c < 8; c++)
            if (c == 0 || c > 3) run_case(5, c % 2, 1'b0, c, 1'b0);
        run_case(10, 1, 1'b1, 4, 1'b1);   // R11 output off: any code accepted
        run_case(TMAX + 5, 0, 1'b0, 2, 1'b0);
        run_case(3, 1, 1'b0, 3, 1'b0);    // R12 error cleared by accepted start
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog (all requirements): got hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule